// File: doc/BRIEF.md
# Interrupt Priority Resolver with Level Rounding

This block picks a single winning interrupt from three kinds of pending request and reports it to the CPU side. The three kinds are a set of on-chip peripheral sources, a few external IRQ lines and one non-maskable line.

Each on-chip source has a writable 5-bit priority. Sources are ranked against each other at the full 5-bit resolution. The CPU side is given only a 4-bit level, which is the 5-bit value with its lowest bit dropped. Each external line comes with its own 4-bit level. An external line beats an on-chip source whenever its level is equal to or higher than the on-chip source's rounded level. The non-maskable request always wins and is reported one step above the highest 4-bit level.

Every source has its own event code. Software uses this code as a branch offset, so the code on the outputs always belongs to the source behind the reported level. The outputs are plain registered status that the CPU side samples at any time. They carry no valid/ready handshake and apply no back-pressure. The result simply follows the inputs one clock later.

Top module: `irq_prio_resolver`

## Requirements
- R1: For an on-chip winner, `res_level` equals its 5-bit priority shifted right by one bit (range 1 to 15).
- R2: Among pending on-chip sources, the larger 5-bit priority wins. This holds even when two sources round to the same 4-bit level, for example 0x1B beats 0x1A and both report level 0xD.
- R3: Pending on-chip sources with identical 5-bit priorities are resolved in favour of the lower source index.
- R4: An on-chip priority of 0 or 1 masks that source, so it is never reported. Settings 2 to 31 are the usable ones.
- R5: A pending NMI beats every other source. It is reported at level 16 with code `NMI_CODE` (default 0x1C0).
- R6: A pending external line with a nonzero level beats the best on-chip candidate when its 4-bit level is greater than or equal to that candidate's rounded level. Otherwise the on-chip candidate wins.
- R7: Among external lines, the higher 4-bit level wins and a tie goes to the lower line index. A line whose level is 0 is masked.
- R8: `res_code` always matches the reported source, using these defaults:
  - on-chip source i: 0x400 + 0x20·i
  - external line j: 0x200 + 0x20·j
  - NMI: 0x1C0
- R9: When no unmasked request is pending, `res_valid` is 0 and both `res_level` and `res_code` are 0.
- R10: Outputs are registered. A change on the request inputs appears on the outputs at the next rising edge. A priority write takes effect at the edge on which it is sampled, so it is visible on the outputs one edge later.
- R11: Synchronous reset clears every on-chip priority to 0 and drives all outputs to 0.
- R12: When `prio_we` is high, `prio_wdata` is written into the priority of source `prio_idx` only. No other source's setting changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prio_we | input | 1 | Write enable for one on-chip priority |
| prio_idx | input | $clog2(N_ONCHIP) | On-chip source being written |
| prio_wdata | input | 5 | New 5-bit priority |
| onchip_req | input | N_ONCHIP | Pending on-chip requests, bit i = source i |
| ext_req | input | N_EXT | Pending external IRQ lines |
| ext_level | input | 4·N_EXT | 4-bit level per external line, line j at bits [4j+3:4j] |
| nmi_req | input | 1 | Pending non-maskable request |
| res_valid | output | 1 | A request is being reported |
| res_level | output | 5 | Reported level: 1 to 15, or 16 for NMI |
| res_code | output | CODE_W | Event code of the reported source |

## Verification
A request pattern driven on a falling edge is captured at the next rising edge and is due on the outputs at once. The scoreboard therefore pops one expected item two nanoseconds after each rising edge, and each item corresponds to the pattern driven half a cycle earlier. A priority write is issued in its own cycle with no check queued. The following stimulus cycle then observes the new setting, which keeps the one-extra-edge latency of R10 visible. The reset state is sampled while reset is still held.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int PRIO_W   = 5;
  localparam int ELVL_W   = 4;
  localparam int LEVEL_W  = 5;
  localparam logic [LEVEL_W-1:0] NMI_LEVEL = 5'd16;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [ELVL_W-1:0] elvl_t;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
#(
  parameter int N_ONCHIP = 8,
  localparam int IDX_W = $clog2(N_ONCHIP)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  prio_t                      wr_data,
  output prio_t [N_ONCHIP-1:0]       prio_q
);
  for (genvar g = 0; g < N_ONCHIP; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        prio_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        prio_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/irq_onchip_pick.sv
module irq_onchip_pick
  import irq_prio_pkg::*;
#(
  parameter int N_ONCHIP = 8,
  localparam int IDX_W = $clog2(N_ONCHIP)
) (
  input  logic [N_ONCHIP-1:0]  req,
  input  prio_t [N_ONCHIP-1:0] prio,
  output logic                 win_vld,
  output prio_t                win_prio,
  output logic [IDX_W-1:0]     win_idx
);
  always_comb begin
    win_vld  = 1'b0;
    win_prio = '0;
    win_idx  = '0;
    for (int i = 0; i < N_ONCHIP; i++) begin
      // rounded level of zero means masked; strict compare keeps lower index on ties
      if (req[i] && (prio[i][PRIO_W-1:1] != '0) && (!win_vld || (prio[i] > win_prio))) begin
        win_vld  = 1'b1;
        win_prio = prio[i];
        win_idx  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ext_pick.sv
module irq_ext_pick
  import irq_prio_pkg::*;
#(
  parameter int N_EXT = 4,
  localparam int EIDX_W = (N_EXT > 1) ? $clog2(N_EXT) : 1
) (
  input  logic [N_EXT-1:0]        req,
  input  logic [N_EXT*ELVL_W-1:0] level,
  output logic                    win_vld,
  output elvl_t                   win_lvl,
  output logic [EIDX_W-1:0]       win_idx
);
  elvl_t lvl [N_EXT];

  for (genvar g = 0; g < N_EXT; g++) begin : g_split
    assign lvl[g] = level[g*ELVL_W +: ELVL_W];
  end

  always_comb begin
    win_vld = 1'b0;
    win_lvl = '0;
    win_idx = '0;
    for (int j = 0; j < N_EXT; j++) begin
      if (req[j] && (lvl[j] != '0) && (!win_vld || (lvl[j] > win_lvl))) begin
        win_vld = 1'b1;
        win_lvl = lvl[j];
        win_idx = EIDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int N_ONCHIP       = 8,
  parameter int N_EXT          = 4,
  parameter int CODE_W         = 12,
  parameter int ONCHIP_CODE0   = 'h400,
  parameter int ONCHIP_STEP    = 'h20,
  parameter int EXT_CODE0      = 'h200,
  parameter int EXT_STEP       = 'h20,
  parameter int NMI_CODE       = 'h1C0,
  localparam int IDX_W  = $clog2(N_ONCHIP),
  localparam int EIDX_W = (N_EXT > 1) ? $clog2(N_EXT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    prio_we,
  input  logic [IDX_W-1:0]        prio_idx,
  input  logic [4:0]              prio_wdata,
  input  logic [N_ONCHIP-1:0]     onchip_req,
  input  logic [N_EXT-1:0]        ext_req,
  input  logic [N_EXT*4-1:0]      ext_level,
  input  logic                    nmi_req,
  output logic                    res_valid,
  output logic [4:0]              res_level,
  output logic [CODE_W-1:0]       res_code
);
  prio_t [N_ONCHIP-1:0] prio_q;

  logic               on_vld;
  prio_t              on_prio;
  logic [IDX_W-1:0]   on_idx;
  logic               ex_vld;
  elvl_t              ex_lvl;
  logic [EIDX_W-1:0]  ex_idx;

  logic               nxt_valid;
  logic [LEVEL_W-1:0] nxt_level;
  logic [CODE_W-1:0]  nxt_code;
  logic               ext_beats_onchip;

  irq_prio_regs #(.N_ONCHIP(N_ONCHIP)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (prio_we),
    .wr_idx  (prio_idx),
    .wr_data (prio_wdata),
    .prio_q  (prio_q)
  );

  irq_onchip_pick #(.N_ONCHIP(N_ONCHIP)) u_onchip (
    .req      (onchip_req),
    .prio     (prio_q),
    .win_vld  (on_vld),
    .win_prio (on_prio),
    .win_idx  (on_idx)
  );

  irq_ext_pick #(.N_EXT(N_EXT)) u_ext (
    .req     (ext_req),
    .level   (ext_level),
    .win_vld (ex_vld),
    .win_lvl (ex_lvl),
    .win_idx (ex_idx)
  );

  // external line wins at an equal rounded level
  assign ext_beats_onchip = ex_vld && (!on_vld || (ex_lvl >= on_prio[PRIO_W-1:1]));

  always_comb begin
    nxt_valid = 1'b0;
    nxt_level = '0;
    nxt_code  = '0;
    if (nmi_req) begin
      nxt_valid = 1'b1;
      nxt_level = NMI_LEVEL;
      nxt_code  = CODE_W'(NMI_CODE);
    end else if (ext_beats_onchip) begin
      nxt_valid = 1'b1;
      nxt_level = LEVEL_W'(ex_lvl);
      nxt_code  = CODE_W'(EXT_CODE0 + EXT_STEP * int'(ex_idx));
    end else if (on_vld) begin
      nxt_valid = 1'b1;
      nxt_level = LEVEL_W'(on_prio[PRIO_W-1:1]);
      nxt_code  = CODE_W'(ONCHIP_CODE0 + ONCHIP_STEP * int'(on_idx));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_level <= '0;
      res_code  <= '0;
    end else begin
      res_valid <= nxt_valid;
      res_level <= nxt_level;
      res_code  <= nxt_code;
    end
  end
endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker #(
  parameter int N_ONCHIP = 8,
  parameter int N_EXT    = 4,
  parameter int CODE_W   = 12,
  parameter int NMI_CODE = 'h1C0
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  prio_we,
  input logic [N_ONCHIP-1:0]   onchip_req,
  input logic [N_EXT-1:0]      ext_req,
  input logic [N_EXT*4-1:0]    ext_level,
  input logic                  nmi_req,
  input logic                  res_valid,
  input logic [4:0]            res_level,
  input logic [CODE_W-1:0]     res_code
);
  AST_NMI_WINS: assert property (@(posedge clk) disable iff (rst)
    nmi_req |=> (res_valid && res_level == 5'd16 && res_code == CODE_W'(NMI_CODE))); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (res_level == '0 && res_code == '0)); // R9

  AST_NOTHING_PENDING: assert property (@(posedge clk) disable iff (rst)
    (onchip_req == '0 && ext_req == '0 && !nmi_req) |=> !res_valid); // R9

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_level != '0 && res_level <= 5'd16)); // R1

  AST_TOP_LEVEL_CODE: assert property (@(posedge clk) disable iff (rst)
    (res_level == 5'd16) |-> (res_code == CODE_W'(NMI_CODE))); // R8

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(prio_we) && $stable(onchip_req) && $stable(ext_req)
      && $stable(ext_level) && $stable(nmi_req))
    |=> ($stable(res_valid) && $stable(res_level) && $stable(res_code))); // R10
endmodule

bind irq_prio_resolver irq_prio_checker #(
  .N_ONCHIP (N_ONCHIP),
  .N_EXT    (N_EXT),
  .CODE_W   (CODE_W),
  .NMI_CODE (NMI_CODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .prio_we    (prio_we),
  .onchip_req (onchip_req),
  .ext_req    (ext_req),
  .ext_level  (ext_level),
  .nmi_req    (nmi_req),
  .res_valid  (res_valid),
  .res_level  (res_level),
  .res_code   (res_code)
);

// File: tb/test_irq_prio_resolver.sv
module test_irq_prio_resolver;
  localparam int NO = 8;
  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prio_we = 1'b0;
  logic [2:0]  prio_idx = '0;
  logic [4:0]  prio_wdata = '0;
  logic [NO-1:0] onchip_req = '0;
  logic [NE-1:0] ext_req = '0;
  logic [NE*4-1:0] ext_level = '0;
  logic        nmi_req = 1'b0;
  logic        res_valid;
  logic [4:0]  res_level;
  logic [11:0] res_code;

  always #5 clk = ~clk;

  irq_prio_resolver i_irq_prio_resolver (
    .clk(clk), .rst(rst), .prio_we(prio_we), .prio_idx(prio_idx),
    .prio_wdata(prio_wdata), .onchip_req(onchip_req), .ext_req(ext_req),
    .ext_level(ext_level), .nmi_req(nmi_req), .res_valid(res_valid),
    .res_level(res_level), .res_code(res_code)
  );

  typedef struct {
    logic        vld;
    logic [4:0]  lvl;
    logic [11:0] code;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  logic [4:0] shadow [NO];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic exp_t model(logic [NO-1:0] oreq, logic [NE-1:0] ereq,
                                 logic [NE*4-1:0] elvl, logic nmi, string tag);
    exp_t e;
    bit of = 0; int bi = 0; logic [4:0] bp = '0;
    bit ef = 0; int bj = 0; logic [3:0] bl = '0;
    e.tag = tag; e.vld = 0; e.lvl = '0; e.code = '0;
    for (int i = 0; i < NO; i++)
      if (oreq[i] && shadow[i] >= 5'd2 && (!of || shadow[i] > bp)) begin
        of = 1; bi = i; bp = shadow[i];
      end
    for (int j = 0; j < NE; j++)
      if (ereq[j] && elvl[j*4 +: 4] != 0 && (!ef || elvl[j*4 +: 4] > bl)) begin
        ef = 1; bj = j; bl = elvl[j*4 +: 4];
      end
    if (nmi) begin
      e.vld = 1; e.lvl = 5'd16; e.code = 12'h1C0;
    end else if (ef && (!of || bl >= bp[4:1])) begin
      e.vld = 1; e.lvl = {1'b0, bl}; e.code = 12'(12'h200 + 12'h20 * bj);
    end else if (of) begin
      e.vld = 1; e.lvl = {1'b0, bp[4:1]}; e.code = 12'(12'h400 + 12'h20 * bi);
    end
    return e;
  endfunction

  task automatic apply(logic [NO-1:0] oreq, logic [NE-1:0] ereq,
                       logic [NE*4-1:0] elvl, logic nmi, string tag);
    @(negedge clk);
    prio_we = 1'b0;
    onchip_req = oreq; ext_req = ereq; ext_level = elvl; nmi_req = nmi;
    sb_q.push_back(model(oreq, ereq, elvl, nmi, tag));
  endtask

  task automatic write_prio(int idx, logic [4:0] val);
    @(negedge clk);
    prio_we = 1'b1; prio_idx = 3'(idx); prio_wdata = val;
    onchip_req = '0; ext_req = '0; nmi_req = 1'b0;
    shadow[idx] = val;
  endtask

  always @(posedge clk) begin
    #2;
    if (sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_vec++;
      if (res_valid !== e.vld || res_level !== e.lvl || res_code !== e.code) begin
        n_bad++;
        $display("FAIL %s: got valid=%0b level=%0d code=%h, expected valid=%0b level=%0d code=%h",
                 e.tag, res_valid, res_level, res_code, e.vld, e.lvl, e.code);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NO; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state seen while reset is held
    n_vec++;
    if (res_valid !== 1'b0 || res_level !== 5'd0 || res_code !== 12'd0) begin
      n_bad++;
      $display("FAIL R11: got valid=%0b level=%0d code=%h, expected 0 0 000",
               res_valid, res_level, res_code);
    end
    rst = 1'b0;

    apply('1, '0, '0, 0, "R11 priorities cleared");
    apply('0, '0, '0, 0, "R9 idle");

    write_prio(0, 5'h1A);
    write_prio(1, 5'h1B);
    apply(8'b0000_0011, '0, '0, 0, "R2 0x1B over 0x1A");
    apply(8'b0000_0001, '0, '0, 0, "R1 0x1A rounds to 0xD");
    write_prio(2, 5'h1B);
    apply(8'b0000_0110, '0, '0, 0, "R3 equal priority lower index");
    write_prio(3, 5'h01);
    write_prio(4, 5'h00);
    write_prio(5, 5'h02);
    apply(8'b0000_1000, '0, '0, 0, "R4 setting 1 masked");
    apply(8'b0001_0000, '0, '0, 0, "R4 setting 0 masked");
    apply(8'b0011_1000, '0, '0, 0, "R4 setting 2 usable");
    apply(8'b0000_0010, 4'b0001, 16'h000D, 0, "R6 ext equal level wins");
    apply(8'b0000_0010, 4'b0001, 16'h000C, 0, "R6 ext lower level loses");
    apply(8'b0000_0000, 4'b0110, 16'h0550, 0, "R7 ext tie lower index");
    apply(8'b0000_0000, 4'b1100, 16'h9300, 0, "R7 ext higher level");
    apply(8'b0010_0000, 4'b0001, 16'h0000, 0, "R7 ext level 0 masked");
    apply('1, '1, 16'hFFFF, 1, "R5 NMI beats all");
    apply('0, '0, '0, 1, "R5 NMI alone");
    apply('0, '0, '0, 0, "R10 drop after one cycle");
    // R12: write one source, the others must be untouched
    write_prio(7, 5'h1F);
    apply(8'b1000_0110, '0, '0, 0, "R12 write source 7 to 0x1F");
    apply(8'b0000_0110, '0, '0, 0, "R12 source 1 unchanged");
    // R10: written value visible in the first checked cycle after the write
    write_prio(1, 5'h04);
    apply(8'b0000_0010, '0, '0, 0, "R10 write latency");
    // R1 R8: sweep every setting on source 6
    for (int p = 0; p < 32; p++) begin
      write_prio(6, 5'(p));
      apply(8'b0100_0000, '0, '0, 0, "R1 R8 sweep");
    end
    for (int j = 0; j < NE; j++)
      apply('0, 4'(1 << j), 16'h7777, 0, "R8 ext codes");
    for (int i = 0; i < NO; i++) begin
      write_prio(i, 5'h10);
      apply(8'(1 << i), '0, '0, 0, "R8 on-chip codes");
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule